// File: doc/BRIEF.md
# Word-Serial Block Cipher Chaining Controller

This block connects a 32-bit register bus to a 128-bit block cipher core that runs in decryption with a key that is already prepared. Software, or a DMA engine, feeds it a ciphertext block as four word writes to a single input address. The fourth write starts the core through a request/acknowledge handshake. The block then applies the chaining step that the selected chaining mode calls for and holds the plaintext. Software collects the plaintext as four word reads from a single output address.

In CBC decryption the plaintext is the core output XOR the chaining value, and the chaining value is then replaced by the ciphertext just processed. The chaining value sits in four readable and writable words. Software can read them back to suspend a message and write them again to resume it.

A sticky completion flag marks each finished block, and software clears it by writing a one to a clear bit. Two DMA request outputs, each with its own enable bit, pace the input and output transfers.

Top module: `cwc_top`

## Requirements
- R1: Word addresses are 0 control, 1 status, 2 data in, 3 data out, and 4..7 chaining words, with address 4 holding the most significant word. The control fields are enable in bit 0, operation in bits 2:1 (2'b10 selects decryption), chaining mode in bits 5:3 (3'b000 ECB, 3'b001 CBC), flag clear in bit 6 (write-one, reads as 0), input DMA enable in bit 7 and output DMA enable in bit 8. Status bit 0 is the completion flag. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R2: A control write leaves the operation and chaining-mode fields unchanged when enable is already set. The other control bits are still written.
- R3: Four data-in writes form one block, most significant word first. The fourth write raises `core_req` on the next edge with `core_din` equal to the block. `core_req` stays high until the cycle in which `core_ack` is seen, and falls after it.
- R4: Data-in writes are ignored while enable is clear. They are also ignored from the fourth write of a block until the fourth data-out read of its result.
- R5: In ECB the plaintext equals `core_dout` as captured on acknowledge.
- R6: In CBC decryption the plaintext is `core_dout` XOR the chaining value. On the same acknowledge the chaining value becomes the ciphertext block just processed.
- R7: The completion flag is set on the cycle after the acknowledge. It stays set until a control write has bit 6 at one.
- R8: After completion, four data-out reads return the plaintext most significant word first. A data-out read at any other time returns 0.
- R9: Clearing enable resets the word counters and drops a pending `core_req`, and no result or flag follows. The chaining words are left unchanged. They accept bus writes only while enable is clear, and they can be read at any time.
- R10: `din_dreq` is high while enabled, input DMA is enabled and the block is awaiting input words. `dout_dreq` is high while enabled, output DMA is enabled and plaintext words remain to be read. Both are low otherwise.
- R11: After reset all control fields, the flag, the chaining words, `core_req` and both DMA requests are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_req | output | 1 | Start request to the cipher core |
| core_op | output | 2 | Operation field passed to the core |
| core_din | output | 128 | Ciphertext block to the core |
| core_ack | input | 1 | Core result valid, ends the request |
| core_dout | input | 128 | Core result |
| din_dreq | output | 1 | DMA request for input words |
| dout_dreq | output | 1 | DMA request for output words |

## Verification
The hardest state to reach from the ports is a request that is aborted while the core is still working. The stand-in core answers after a set latency, so the bench raises that latency well beyond the length of one bus write. It then clears enable while `core_req` is high and checks three things: the request drops, no flag appears, and the chaining words read back unchanged. A second hard case is a data-in write that arrives during the unload phase. The bench sends four such writes, which would form a whole block if any were taken, and then checks both the pending plaintext and the next genuine block.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  // word addresses on the register bus
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_DIN  = 2;
  localparam int A_DOUT = 3;
  localparam int A_IV   = 4;

  // control register bit positions
  localparam int B_EN     = 0;
  localparam int B_OP_LO  = 1;
  localparam int B_CH_LO  = 3;
  localparam int B_CLR    = 6;
  localparam int B_DMAIN  = 7;
  localparam int B_DMAOUT = 8;

  localparam logic [1:0] OP_DECRYPT = 2'b10;
  localparam logic [2:0] CH_ECB     = 3'b000;
  localparam logic [2:0] CH_CBC     = 3'b001;

  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_UNLOAD = 2'd2
  } seq_st_t;
endpackage

// File: rtl/cwc_ctrl_regs.sv
module cwc_ctrl_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic       w_en,
  input  logic [1:0] w_op,
  input  logic [2:0] w_chain,
  input  logic       w_dmain,
  input  logic       w_dmaout,
  input  logic       clr_wr,
  input  logic       set_flag,
  output logic       en_q,
  output logic       en_d,
  output logic [1:0] op_q,
  output logic [2:0] chain_q,
  output logic       dmain_q,
  output logic       dmaout_q,
  output logic       flag_q
);
  always_comb en_d = ctrl_wr ? w_en : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      op_q     <= '0;
      chain_q  <= '0;
      dmain_q  <= 1'b0;
      dmaout_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      en_q <= en_d;
      if (ctrl_wr) begin
        dmain_q  <= w_dmain;
        dmaout_q <= w_dmaout;
        if (!en_q) begin
          op_q    <= w_op;
          chain_q <= w_chain;
        end
      end
      if (set_flag)    flag_q <= 1'b1;
      else if (clr_wr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cwc_seq.sv
module cwc_seq #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_d,
  input  logic              din_wr,
  input  logic [WORD_W-1:0] din,
  input  logic              dout_rd,
  input  logic              core_ack,
  input  logic [BLK_W-1:0]  plain,
  output logic              core_req,
  output logic [BLK_W-1:0]  blk_q,
  output logic              fire,
  output logic              loading,
  output logic              unloading,
  output logic [WORD_W-1:0] out_word
);
  import cwc_pkg::*;
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  seq_st_t          st;
  logic [CNT_W-1:0] in_cnt, out_cnt;
  logic [BLK_W-1:0] res_q;

  assign fire      = (st == ST_BUSY) && core_ack && en_d;
  assign loading   = (st == ST_LOAD);
  assign unloading = (st == ST_UNLOAD);
  assign out_word  = res_q[BLK_W-1 -: WORD_W];

  always_ff @(posedge clk) begin
    if (rst || !en_d) begin
      st       <= ST_LOAD;
      in_cnt   <= '0;
      out_cnt  <= '0;
      core_req <= 1'b0;
    end else begin
      unique case (st)
        ST_LOAD: if (din_wr) begin
          blk_q <= {blk_q[BLK_W-WORD_W-1:0], din};
          if (in_cnt == LAST) begin
            in_cnt   <= '0;
            st       <= ST_BUSY;
            core_req <= 1'b1;
          end else begin
            in_cnt <= in_cnt + 1'b1;
          end
        end
        ST_BUSY: if (core_ack) begin
          core_req <= 1'b0;
          res_q    <= plain;
          st       <= ST_UNLOAD;
        end
        ST_UNLOAD: if (dout_rd) begin
          res_q <= res_q << WORD_W;
          if (out_cnt == LAST) begin
            out_cnt <= '0;
            st      <= ST_LOAD;
          end else begin
            out_cnt <= out_cnt + 1'b1;
          end
        end
        default: st <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/cwc_chain.sv
module cwc_chain #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORD_W * WORDS,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iv_wr,
  input  logic [IDX_W-1:0]  iv_idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              hw_upd,
  input  logic              cbc_dec,
  input  logic [BLK_W-1:0]  ct,
  input  logic [BLK_W-1:0]  core_dout,
  output logic [BLK_W-1:0]  iv_flat,
  output logic [BLK_W-1:0]  plain
);
  // word k of the chaining value; k = 0 is the most significant
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk) begin
      if (rst)
        w_q <= '0;
      else if (hw_upd)
        w_q <= ct[BLK_W-1-k*WORD_W -: WORD_W];
      else if (iv_wr && iv_idx == IDX_W'(k))
        w_q <= wdata;
    end
    assign iv_flat[BLK_W-1-k*WORD_W -: WORD_W] = w_q;
  end

  assign plain = core_dout ^ (cbc_dec ? iv_flat : '0);
endmodule

// File: rtl/cwc_top.sv
module cwc_top #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 3,
  localparam int BLK_W = WORD_W * WORDS,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              core_req,
  output logic [1:0]        core_op,
  output logic [BLK_W-1:0]  core_din,
  input  logic              core_ack,
  input  logic [BLK_W-1:0]  core_dout,
  output logic              din_dreq,
  output logic              dout_dreq
);
  import cwc_pkg::*;
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_DIN  = ADDR_W'(A_DIN);
  localparam logic [ADDR_W-1:0] AD_DOUT = ADDR_W'(A_DOUT);
  localparam logic [ADDR_W-1:0] AD_IV   = ADDR_W'(A_IV);

  logic              en_q, en_d, dmain_q, dmaout_q, flag_q;
  logic [1:0]        op_q;
  logic [2:0]        chain_q;
  logic              ctrl_wr, clr_wr, din_wr, dout_rd, iv_wr, in_iv;
  logic [ADDR_W-1:0] iv_off;
  logic [IDX_W-1:0]  iv_idx;
  logic              fire, loading, unloading, cbc_dec;
  logic [BLK_W-1:0]  blk_q, plain, iv_flat;
  logic [WORD_W-1:0] out_word;

  assign ctrl_wr = bus_wr && bus_addr == AD_CTRL;
  assign clr_wr  = ctrl_wr && bus_wdata[B_CLR];
  assign din_wr  = bus_wr && bus_addr == AD_DIN;
  assign dout_rd = bus_rd && bus_addr == AD_DOUT;
  assign iv_off  = bus_addr - AD_IV;
  assign iv_idx  = iv_off[IDX_W-1:0];
  assign in_iv   = (bus_addr >= AD_IV) && (iv_off < ADDR_W'(WORDS));
  assign iv_wr   = bus_wr && in_iv && !en_q;
  assign cbc_dec = en_q && op_q == OP_DECRYPT && chain_q == CH_CBC;

  cwc_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (ctrl_wr),
    .w_en     (bus_wdata[B_EN]),
    .w_op     (bus_wdata[B_OP_LO +: 2]),
    .w_chain  (bus_wdata[B_CH_LO +: 3]),
    .w_dmain  (bus_wdata[B_DMAIN]),
    .w_dmaout (bus_wdata[B_DMAOUT]),
    .clr_wr   (clr_wr),
    .set_flag (fire),
    .en_q     (en_q),
    .en_d     (en_d),
    .op_q     (op_q),
    .chain_q  (chain_q),
    .dmain_q  (dmain_q),
    .dmaout_q (dmaout_q),
    .flag_q   (flag_q)
  );

  cwc_seq #(.WORD_W(WORD_W), .WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en_d      (en_d),
    .din_wr    (din_wr),
    .din       (bus_wdata),
    .dout_rd   (dout_rd),
    .core_ack  (core_ack),
    .plain     (plain),
    .core_req  (core_req),
    .blk_q     (blk_q),
    .fire      (fire),
    .loading   (loading),
    .unloading (unloading),
    .out_word  (out_word)
  );

  cwc_chain #(.WORD_W(WORD_W), .WORDS(WORDS)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .iv_wr     (iv_wr),
    .iv_idx    (iv_idx),
    .wdata     (bus_wdata),
    .hw_upd    (fire && cbc_dec),
    .cbc_dec   (cbc_dec),
    .ct        (blk_q),
    .core_dout (core_dout),
    .iv_flat   (iv_flat),
    .plain     (plain)
  );

  assign core_din  = blk_q;
  assign core_op   = op_q;
  assign din_dreq  = en_q && dmain_q && loading;
  assign dout_dreq = en_q && dmaout_q && unloading;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (bus_addr == AD_CTRL) begin
        bus_rdata[B_EN]         <= en_q;
        bus_rdata[B_OP_LO +: 2] <= op_q;
        bus_rdata[B_CH_LO +: 3] <= chain_q;
        bus_rdata[B_DMAIN]      <= dmain_q;
        bus_rdata[B_DMAOUT]     <= dmaout_q;
      end else if (bus_addr == AD_STAT) begin
        bus_rdata[0] <= flag_q;
      end else if (bus_addr == AD_DOUT) begin
        if (unloading) bus_rdata <= out_word;
      end else if (in_iv) begin
        bus_rdata <= iv_flat[BLK_W-1-int'(iv_idx)*WORD_W -: WORD_W];
      end
    end
  end
endmodule

// File: rtl/cwc_checker.sv
module cwc_checker #(
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic             ctrl_wr,
  input logic             new_en,
  input logic             clr_wr,
  input logic             iv_wr,
  input logic             flag_q,
  input logic             core_req,
  input logic             core_ack,
  input logic             din_dreq,
  input logic             dout_dreq,
  input logic [BLK_W-1:0] iv_flat
);
  // R3: request held until acknowledged (or aborted)
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (core_req && !core_ack) |=> (core_req || !en_q));

  // R3: request falls after acknowledge
  p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (core_req && core_ack) |=> !core_req);

  // R7: acknowledge sets the flag unless enable is being cleared
  p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    (core_req && core_ack && !(ctrl_wr && !new_en)) |=> flag_q);

  // R7: flag is sticky until a clear write
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_wr) |=> flag_q);

  // R9: no request or DMA activity while disabled
  p_idle_off_r9: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (!core_req && !din_dreq && !dout_dreq));

  // R9: chaining words hold while disabled without a write
  p_iv_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !iv_wr) |=> $stable(iv_flat));

  // R10: input and output DMA requests never overlap
  p_dreq_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(din_dreq && dout_dreq));
endmodule

bind cwc_top cwc_checker #(.BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_q      (en_q),
  .ctrl_wr   (ctrl_wr),
  .new_en    (en_d),
  .clr_wr    (clr_wr),
  .iv_wr     (iv_wr),
  .flag_q    (flag_q),
  .core_req  (core_req),
  .core_ack  (core_ack),
  .din_dreq  (din_dreq),
  .dout_dreq (dout_dreq),
  .iv_flat   (iv_flat)
);

// File: tb/sim_cwc_top.sv
module sim_cwc_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         core_req;
  logic [1:0]   core_op;
  logic [127:0] core_din;
  logic         core_ack = 1'b0;
  logic [127:0] core_dout = '0;
  logic         din_dreq, dout_dreq;

  int vectors = 0;
  int miscompares = 0;
  int core_lat = 3;

  always #4 clk = ~clk;

  cwc_top u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_req(core_req), .core_op(core_op), .core_din(core_din),
    .core_ack(core_ack), .core_dout(core_dout),
    .din_dreq(din_dreq), .dout_dreq(dout_dreq)
  );

  // behavioural stand-in for the cipher core
  function automatic logic [127:0] fcore(input logic [127:0] x);
    return {x[95:0], x[127:96]} ^ 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
  endfunction

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (core_ack) core_ack = 1'b0;
      else if (core_req) begin
        cnt++;
        if (cnt >= core_lat) begin
          core_ack = 1'b1;
          core_dout = fcore(core_din);
          cnt = 0;
        end
      end else cnt = 0;
    end
  end

  function automatic logic [31:0] cw(input logic en, input logic [1:0] op,
      input logic [2:0] ch, input logic di, input logic dq, input logic clr);
    return {23'd0, dq, di, clr, ch, op, en};
  endfunction

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic load_block(input logic [127:0] ct);
    for (int i = 0; i < 4; i++) wr(3'd2, ct[127-32*i -: 32]);
  endtask

  task automatic read_block(output logic [127:0] pt);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      rd(3'd3, w);
      pt[127-32*i -: 32] = w;
    end
  endtask

  task automatic wait_flag();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      rd(3'd1, s);
      if (s[0]) break;
    end
  endtask

  task automatic read_iv(output logic [127:0] iv);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), w);
      iv[127-32*i -: 32] = w;
    end
  endtask

  task automatic write_iv(input logic [127:0] iv);
    for (int i = 0; i < 4; i++) wr(3'(4 + i), iv[127-32*i -: 32]);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [127:0] iv;
    rd(3'd0, d); chk("R11 ctrl after reset", 128'(d), 128'd0);
    rd(3'd1, d); chk("R11 flag after reset", 128'(d), 128'd0);
    read_iv(iv); chk("R11 chaining after reset", iv, 128'd0);
    chk("R11 req/dreq after reset", 128'({core_req, din_dreq, dout_dreq}), 128'd0);
    rd(3'd3, d); chk("R8 dout idle reads 0", 128'(d), 128'd0);
  endtask

  task automatic t_ecb();
    logic [127:0] ct = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    logic [127:0] pt;
    logic [31:0] d;
    wr(3'd0, cw(1, 2'b10, 3'b000, 0, 0, 0));
    rd(3'd0, d); chk("R1 ctrl readback", 128'(d), 128'(cw(1, 2'b10, 3'b000, 0, 0, 0)));
    chk("R1 core_op", 128'(core_op), 128'(2'b10));
    load_block(ct);
    chk("R3 req after fourth write", 128'(core_req), 128'd1);
    chk("R3 core_din order", core_din, ct);
    wait_flag();
    chk("R7 flag set", 128'(u0.bus_rdata[0]), 128'd1);
    read_block(pt);
    chk("R5 R8 ECB plaintext", pt, fcore(ct));
    rd(3'd1, d); chk("R7 flag sticky after reads", 128'(d), 128'd1);
    wr(3'd0, cw(1, 2'b10, 3'b000, 0, 0, 1));
    rd(3'd1, d); chk("R7 flag cleared", 128'(d), 128'd0);
  endtask

  task automatic t_cbc();
    logic [127:0] iv  = 128'hDEADBEEF_01234567_89ABCDEF_FEDCBA98;
    logic [127:0] ct1 = 128'h11111111_22222222_33333333_44444444;
    logic [127:0] ct2 = 128'hA0A1A2A3_B0B1B2B3_C0C1C2C3_D0D1D2D3;
    logic [127:0] pt, rb;
    wr(3'd0, 32'd0);
    write_iv(iv);
    read_iv(rb); chk("R9 chaining write while disabled", rb, iv);
    wr(3'd0, cw(1, 2'b10, 3'b001, 0, 0, 0));
    load_block(ct1); wait_flag(); read_block(pt);
    chk("R6 CBC first block", pt, fcore(ct1) ^ iv);
    read_iv(rb); chk("R6 chaining updated to ct1", rb, ct1);
    wr(3'd0, cw(1, 2'b10, 3'b001, 0, 0, 1));
    load_block(ct2); wait_flag(); read_block(pt);
    chk("R6 CBC second block", pt, fcore(ct2) ^ ct1);
    read_iv(rb); chk("R6 chaining updated to ct2", rb, ct2);
    wr(3'd0, cw(1, 2'b10, 3'b001, 0, 0, 1));
  endtask

  task automatic t_ignore();
    logic [127:0] ct3 = 128'h5555AAAA_6666BBBB_7777CCCC_8888DDDD;
    logic [127:0] ct4 = 128'h0BADF00D_CAFEBABE_13579BDF_2468ACE0;
    logic [127:0] ct5 = 128'hFEEDFACE_0F0F0F0F_F0F0F0F0_12121212;
    logic [127:0] pt;
    wr(3'd0, 32'd0);
    wr(3'd0, cw(1, 2'b10, 3'b000, 0, 0, 0));
    load_block(ct3); wait_flag();
    for (int i = 0; i < 4; i++) wr(3'd2, 32'hBAD0_0000 + i);
    chk("R4 no request from writes during unload", 128'(core_req), 128'd0);
    read_block(pt); chk("R4 plaintext intact", pt, fcore(ct3));
    wr(3'd0, cw(1, 2'b10, 3'b000, 0, 0, 1));
    load_block(ct4); wait_flag(); read_block(pt);
    chk("R4 next block aligned", pt, fcore(ct4));
    wr(3'd0, cw(0, 2'b10, 3'b000, 0, 0, 1));
    wr(3'd2, 32'h1234_5678); wr(3'd2, 32'h9ABC_DEF0);
    wr(3'd0, cw(1, 2'b10, 3'b000, 0, 0, 0));
    load_block(ct5); wait_flag(); read_block(pt);
    chk("R4 writes while disabled ignored", pt, fcore(ct5));
    wr(3'd0, cw(1, 2'b10, 3'b000, 0, 0, 1));
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(3'd0, cw(1, 2'b01, 3'b001, 1, 0, 0));
    rd(3'd0, d);
    chk("R2 mode/chain locked while enabled", 128'(d), 128'(cw(1, 2'b10, 3'b000, 1, 0, 0)));
    wr(3'd0, 32'd0);
  endtask

  task automatic t_abort();
    logic [127:0] iva = 128'h76543210_FEDCBA98_01020304_A5A55A5A;
    logic [127:0] ct  = 128'h31415926_53589793_23846264_33832795;
    logic [127:0] rb, pt;
    logic [31:0] d;
    wr(3'd0, 32'd0);
    write_iv(iva);
    wr(3'd0, cw(1, 2'b10, 3'b001, 0, 0, 0));
    wr(3'd4, 32'hFFFF_FFFF);
    read_iv(rb); chk("R9 chaining write ignored while enabled", rb, iva);
    core_lat = 40;
    load_block(ct);
    chk("R9 request pending", 128'(core_req), 128'd1);
    wr(3'd0, 32'd0);
    chk("R9 request dropped on disable", 128'(core_req), 128'd0);
    core_lat = 3;
    repeat (50) @(negedge clk);
    rd(3'd1, d); chk("R9 no flag after abort", 128'(d), 128'd0);
    read_iv(rb); chk("R9 chaining unchanged by abort", rb, iva);
    wr(3'd0, cw(1, 2'b10, 3'b001, 0, 0, 0));
    wr(3'd2, 32'h7777_7777); wr(3'd2, 32'h8888_8888);
    wr(3'd0, cw(0, 2'b10, 3'b001, 0, 0, 0));
    wr(3'd0, cw(1, 2'b10, 3'b001, 0, 0, 0));
    load_block(ct); wait_flag(); read_block(pt);
    chk("R9 counter reset by disable", pt, fcore(ct) ^ iva);
    wr(3'd0, cw(0, 2'b10, 3'b001, 0, 0, 1));
  endtask

  task automatic t_dma();
    logic [127:0] ct = 128'hC001D00D_0000FFFF_FFFF0000_12345678;
    logic [127:0] pt;
    wr(3'd0, cw(1, 2'b10, 3'b000, 1, 1, 0));
    chk("R10 input dreq while loading", 128'({din_dreq, dout_dreq}), 128'b10);
    load_block(ct);
    chk("R10 no dreq while computing", 128'({din_dreq, dout_dreq}), 128'b00);
    wait_flag();
    chk("R10 output dreq while unloading", 128'({din_dreq, dout_dreq}), 128'b01);
    read_block(pt); chk("R10 R8 plaintext via dma phase", pt, fcore(ct));
    chk("R10 input dreq after unload", 128'({din_dreq, dout_dreq}), 128'b10);
    wr(3'd0, cw(1, 2'b10, 3'b000, 0, 0, 1));
    chk("R10 dreq off after clearing enables", 128'({din_dreq, dout_dreq}), 128'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ecb();
    t_cbc();
    t_ignore();
    t_lock();
    t_abort();
    t_dma();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule